// File: doc/BRIEF.md
# Page-mode ROM read controller

This block lets a clocked requester read bursts from an asynchronous parallel ROM that offers a fast in-page access. A request carries a start address, a beat count and a flag that selects 16-bit word reads or 8-bit byte reads. The controller drives the ROM's chip-enable, output-enable, word/byte select and address pins. It waits a parameterised number of clock cycles before it samples the data bus. The sampled beats go out on a valid/ready stream, and the final beat is tagged.

The ROM groups its contents into pages of four words or eight bytes. When the next beat stays inside the current page, only the low offset bits change and the short page wait applies. When a burst steps into a new page, the upper address changes and the long random-access wait applies again. In byte mode the ROM pin that carries data bit 15 in word mode becomes the least-significant byte address input. The controller drives that pin through a separate output with a direction flag.

Between bursts the ROM is put in standby. A fixed float interval with both enables high then passes before the next request is accepted. Wait counts are given in clock cycles and must be at least 1.

Top module: `prom_page_reader`

## Requirements
- R1: After reset, `rom_ce_n_o` and `rom_oe_n_o` are high, `rd_valid_o` is low, `req_ready_o` is high and `rom_word_o` is high (word mode).
- R2: In word mode (`req_byte_i`=0), `req_addr_i` counts words. Each beat drives `rom_addr_o` with the low 19 bits of the word address and `rom_word_o`=1, with `rom_lsb_oe_o`=0. The beat returns all 16 data bits.
- R3: In byte mode (`req_byte_i`=1), `req_addr_i` counts bytes. Each beat drives `rom_addr_o` = byte address >> 1, `rom_lsb_o` = byte address bit 0, `rom_lsb_oe_o`=1 and `rom_word_o`=0. The beat returns data bits 7:0 on `rd_data_o[7:0]`, with bits 15:8 zero.
- R4: The first beat of a burst is sampled max(WAIT_RANDOM, WAIT_OE) cycles after the clock edge that accepts the request and drives the address and both enables.
- R5: A beat whose address shares its page with the previous beat is sampled WAIT_PAGE cycles after the handshake edge of the previous beat. The page offset is address bits 1:0 in word mode and bits 2:0 of the byte address in byte mode.
- R6: A beat that enters a new page (the previous offset was all ones) is sampled WAIT_RANDOM cycles after the previous handshake.
- R7: While a beat is pending or presented, both enables stay low. Inside a page the address bits above the offset do not change.
- R8: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_data_o`, `rd_last_o` and the ROM address pins hold their values.
- R9: A burst with `req_len_i`=N delivers N+1 beats, and `rd_last_o` is high only on the final one.
- R10: After the final handshake, both enables stay high and `req_ready_o` stays low for WAIT_FLOAT cycles. Then `req_ready_o` rises.
- R11: `req_ready_o` is high only while no burst is active. A request is taken only when `req_valid_i` and `req_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, can take a request |
| req_addr_i | input | 20 | Start address, in words or bytes according to the mode |
| req_len_i | input | 8 | Number of beats minus one |
| req_byte_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| rom_ce_n_o | output | 1 | ROM chip enable, active low |
| rom_oe_n_o | output | 1 | ROM output enable, active low |
| rom_word_o | output | 1 | ROM word/byte select, high selects word |
| rom_addr_o | output | 19 | ROM word address pins |
| rom_lsb_o | output | 1 | Byte-address LSB driven onto the shared data-15 pin |
| rom_lsb_oe_o | output | 1 | Direction flag: controller drives the shared pin |
| rom_data_i | input | 16 | ROM data bus |
| rd_valid_o | output | 1 | Read beat valid |
| rd_ready_i | input | 1 | Consumer ready |
| rd_data_o | output | 16 | Read beat data |
| rd_last_o | output | 1 | Final beat of the burst |

## Verification
The hardest case to reach is a stalled beat that sits just before a page boundary in byte mode. The shared LSB pin, the held address and the random-access fallback all meet there. The bench models a ROM whose data bus shows a poison value until each delay counted from the last pin change has passed, so any early sample shows up as wrong data. Bursts start at offsets close to page ends in both modes, and the ready line follows a pseudo-random pattern, so that stalls land both inside pages and on crossing beats.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_HOLD,
    ST_FLOAT
  } rd_state_e;
endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // counting phase decrements by exactly one per cycle (R4, R5, R6, R10)
  p_timer_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/prom_addr_seq.sv
module prom_addr_seq #(
  parameter int ROM_AW = 19,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ROM_AW:0]   load_addr_i,
  input  logic              load_byte_i,
  input  logic              step_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_lsb_o,
  output logic              byte_mode_o,
  output logic              page_end_o
);
  logic [ROM_AW:0] cur_q;
  logic            byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      byte_q <= 1'b0;
    end else if (load_i) begin
      cur_q  <= load_addr_i;
      byte_q <= load_byte_i;
    end else if (step_i) begin
      cur_q  <= cur_q + 1'b1;
    end
  end

  always_comb begin
    if (byte_q) begin
      rom_addr_o = cur_q[ROM_AW:1];
      rom_lsb_o  = cur_q[0];
      page_end_o = &cur_q[PAGE_W:0];
    end else begin
      rom_addr_o = cur_q[ROM_AW-1:0];
      rom_lsb_o  = 1'b0;
      page_end_o = &cur_q[PAGE_W-1:0];
    end
  end

  assign byte_mode_o = byte_q;

  // in-page step leaves the upper address untouched
  p_page_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !page_end_o) |=>
      (rom_addr_o[ROM_AW-1:PAGE_W] == $past(rom_addr_o[ROM_AW-1:PAGE_W])));
  // crossing step moves the upper address
  p_page_cross_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && page_end_o) |=>
      (rom_addr_o[ROM_AW-1:PAGE_W] != $past(rom_addr_o[ROM_AW-1:PAGE_W])));
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_pkg::*;
#(
  parameter int ROM_AW      = 19,
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 2,
  parameter int LEN_W       = 8,
  parameter int WAIT_RANDOM = 25,
  parameter int WAIT_PAGE   = 8,
  parameter int WAIT_OE     = 8,
  parameter int WAIT_FLOAT  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ROM_AW:0]   req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_byte_i,
  output logic              rom_ce_n_o,
  output logic              rom_oe_n_o,
  output logic              rom_word_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_lsb_o,
  output logic              rom_lsb_oe_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o
);
  localparam int WAIT_FIRST = (WAIT_RANDOM > WAIT_OE) ? WAIT_RANDOM : WAIT_OE;
  localparam int WAIT_A     = (WAIT_FIRST > WAIT_PAGE) ? WAIT_FIRST : WAIT_PAGE;
  localparam int WAIT_MAX   = (WAIT_A > WAIT_FLOAT) ? WAIT_A : WAIT_FLOAT;
  localparam int CNT_W      = $clog2(WAIT_MAX + 1);
  localparam int BYTE_W     = DATA_W / 2;

  rd_state_e         state_q;
  logic [LEN_W-1:0]  rem_q;
  logic              rd_valid_q, rd_last_q;
  logic [DATA_W-1:0] rd_data_q;

  logic             accept, hs, step, tmr_load, tmr_done, byte_mode, page_end;
  logic [CNT_W-1:0] tmr_val;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign hs     = rd_valid_q && rd_ready_i;
  assign step   = hs && (rem_q != '0);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(WAIT_FIRST - 1);
    end else if (hs) begin
      tmr_load = 1'b1;
      if (rem_q == '0)   tmr_val = CNT_W'(WAIT_FLOAT - 1);
      else if (page_end) tmr_val = CNT_W'(WAIT_RANDOM - 1);
      else               tmr_val = CNT_W'(WAIT_PAGE - 1);
    end
  end

  prom_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  prom_addr_seq #(.ROM_AW(ROM_AW), .PAGE_W(PAGE_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_addr_i (req_addr_i),
    .load_byte_i (req_byte_i),
    .step_i      (step),
    .rom_addr_o  (rom_addr_o),
    .rom_lsb_o   (rom_lsb_o),
    .byte_mode_o (byte_mode),
    .page_end_o  (page_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_last_q  <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ACCESS;
          rem_q   <= req_len_i;
        end
        ST_ACCESS: if (tmr_done) begin
          rd_valid_q <= 1'b1;
          rd_last_q  <= (rem_q == '0);
          rd_data_q  <= byte_mode ? {{(DATA_W-BYTE_W){1'b0}}, rom_data_i[BYTE_W-1:0]}
                                  : rom_data_i;
          state_q    <= ST_HOLD;
        end
        ST_HOLD: if (hs) begin
          rd_valid_q <= 1'b0;
          if (rem_q == '0) state_q <= ST_FLOAT;
          else begin
            rem_q   <= rem_q - 1'b1;
            state_q <= ST_ACCESS;
          end
        end
        ST_FLOAT: if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rom_ce_n_o   = !((state_q == ST_ACCESS) || (state_q == ST_HOLD));
  assign rom_oe_n_o   = rom_ce_n_o;
  assign rom_word_o   = !byte_mode;
  assign rom_lsb_oe_o = byte_mode;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
  assign rd_last_o    = rd_last_q;

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=>
      (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o) && $stable(rom_addr_o)));
  p_beat_enables_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!rom_ce_n_o && !rom_oe_n_o));
  p_ready_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (rom_ce_n_o && !rd_valid_o));
  p_float_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && rd_last_o) |=> (rom_ce_n_o && rom_oe_n_o && !req_ready_o));
  p_byte_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rom_word_o) |-> (rd_data_o[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/prom_page_reader_test.sv
module prom_page_reader_test;
  localparam int WR = 25, WP = 8, WOE = 8, WF = 5;
  localparam int WFIRST = (WR > WOE) ? WR : WOE;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        req_valid_i = 1'b0, req_byte_i = 1'b0, rd_ready_i = 1'b1;
  logic [19:0] req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic        req_ready_o, rom_ce_n_o, rom_oe_n_o, rom_word_o, rom_lsb_o, rom_lsb_oe_o;
  logic [18:0] rom_addr_o;
  logic [15:0] rom_data_i = 16'hDEAD;
  logic        rd_valid_o, rd_last_o;
  logic [15:0] rd_data_o;

  prom_page_reader #(
    .ROM_AW(19), .DATA_W(16), .PAGE_W(2), .LEN_W(8),
    .WAIT_RANDOM(WR), .WAIT_PAGE(WP), .WAIT_OE(WOE), .WAIT_FLOAT(WF)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_byte_i(req_byte_i),
    .rom_ce_n_o(rom_ce_n_o), .rom_oe_n_o(rom_oe_n_o), .rom_word_o(rom_word_o),
    .rom_addr_o(rom_addr_o), .rom_lsb_o(rom_lsb_o), .rom_lsb_oe_o(rom_lsb_oe_o),
    .rom_data_i(rom_data_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_data_o(rd_data_o), .rd_last_o(rd_last_o)
  );

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [18:0] w);
    return {w[7:0], w[15:8]} ^ {w[18:16], 13'h0} ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] rom_byte(input logic [19:0] b);
    logic [15:0] w;
    w = rom_word(b[19:1]);
    return b[0] ? w[15:8] : w[7:0];
  endfunction

  // ROM model: data is poisoned until every delay since the last pin change has passed
  logic [19:0] m_key = '1;
  logic        m_oe = 1'b1;
  logic [2:0]  m_off = '1;
  int rnd_cnt = 0, pg_cnt = 0, oe_cnt = 0;
  always @(negedge clk) begin
    logic [19:0] key;
    logic [2:0]  off;
    key = {rom_ce_n_o, rom_word_o, rom_addr_o[18:2]};
    off = {rom_addr_o[1:0], rom_word_o ? 1'b0 : rom_lsb_o};
    if (key != m_key) rnd_cnt = 0; else if (rnd_cnt < 1000) rnd_cnt++;
    if (off != m_off) pg_cnt = 0;  else if (pg_cnt < 1000) pg_cnt++;
    if (rom_oe_n_o != m_oe) oe_cnt = 0; else if (oe_cnt < 1000) oe_cnt++;
    m_key = key; m_off = off; m_oe = rom_oe_n_o;
    if (!rom_ce_n_o && !rom_oe_n_o && rnd_cnt >= WR-1 && pg_cnt >= WP-1 && oe_cnt >= WOE-1)
      rom_data_i = rom_word_o ? rom_word(rom_addr_o)
                              : {1'b0, 7'h55, rom_byte({rom_addr_o, rom_lsb_o})};
    else
      rom_data_i = 16'hDEAD;
  end

  // reference model of the stream
  int q_data[$], q_addr[$], q_lsb[$], q_wait[$];
  bit q_last[$];
  bit go = 0, in_burst = 0, float_mode = 0, was_valid = 0, stalled = 0, b_byte = 0, stall_mode = 0;
  logic [19:0] b_addr;
  int b_len, done_cnt = 0, since = 0;
  logic [15:0] held_data;
  logic [18:0] held_addr;
  bit held_last;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    logic [19:0] ua, pa;
    int mask;
    if (rst_n) begin
      since++;
      if (req_valid_i) req_valid_i = 1'b0;
      else if (go && req_ready_o && !in_burst) begin
        req_valid_i = 1'b1; req_addr_i = b_addr; req_len_i = 8'(b_len); req_byte_i = b_byte;
        mask = b_byte ? 7 : 3;
        for (int k = 0; k <= b_len; k++) begin
          ua = b_addr + 20'(k);
          pa = ua - 20'd1;
          if (!b_byte) begin ua[19] = 1'b0; pa[19] = 1'b0; end
          q_data.push_back(b_byte ? int'({8'h00, rom_byte(ua)}) : int'(rom_word(ua[18:0])));
          q_addr.push_back(b_byte ? int'(ua[19:1]) : int'(ua[18:0]));
          q_lsb.push_back(b_byte ? int'(ua[0]) : 0);
          q_wait.push_back(k == 0 ? WFIRST : ((int'(pa) & mask) == mask ? WR : WP));
          q_last.push_back(k == b_len);
        end
        since = -1; in_burst = 1; go = 0;
      end

      if (stalled) begin
        check(rd_valid_o == 1'b1, "R8 valid held", rd_valid_o, 1);
        check(rd_data_o == held_data && rd_last_o == held_last, "R8 data held", rd_data_o, held_data);
        check(rom_addr_o == held_addr, "R8 addr held", rom_addr_o, held_addr);
      end

      if (rd_valid_o && !was_valid && q_data.size() > 0) begin
        check(since == q_wait[0], "R4/R5/R6 beat latency", since, q_wait[0]);
        check(rd_data_o == 16'(q_data[0]), b_byte ? "R3 byte data" : "R2 word data", rd_data_o, q_data[0]);
        check(rom_addr_o == 19'(q_addr[0]), b_byte ? "R3 addr pins" : "R2 addr pins", rom_addr_o, q_addr[0]);
        check(rom_word_o == !b_byte && rom_lsb_oe_o == b_byte, "R2/R3 mode pins",
              {rom_word_o, rom_lsb_oe_o}, {!b_byte, b_byte});
        if (b_byte) check(rom_lsb_o == q_lsb[0][0], "R3 lsb pin", rom_lsb_o, q_lsb[0]);
        check(!rom_ce_n_o && !rom_oe_n_o, "R7 enables low", {rom_ce_n_o, rom_oe_n_o}, 0);
        check(rd_last_o == q_last[0], "R9 last flag", rd_last_o, q_last[0]);
        check(!req_ready_o, "R11 ready low in burst", req_ready_o, 0);
      end
      was_valid = rd_valid_o;

      if (float_mode && since >= 0) begin
        if (req_ready_o) begin
          check(since == WF, "R10 float length", since, WF);
          check(q_data.size() == 0, "R9 beat count", q_data.size(), 0);
          float_mode = 0; in_burst = 0; done_cnt++;
        end else begin
          check(rom_ce_n_o && rom_oe_n_o, "R10 enables high in float", {rom_ce_n_o, rom_oe_n_o}, 3);
        end
      end

      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_ready_i = stall_mode ? lfsr[0] : 1'b1;
      stalled = rd_valid_o && !rd_ready_i;
      held_data = rd_data_o; held_addr = rom_addr_o; held_last = rd_last_o;
      if (rd_valid_o && rd_ready_i && q_data.size() > 0) begin
        if (q_last[0]) float_mode = 1;
        void'(q_data.pop_front()); void'(q_addr.pop_front()); void'(q_lsb.pop_front());
        void'(q_wait.pop_front()); void'(q_last.pop_front());
        since = -1;
      end
    end
  end

  task automatic run(input logic [19:0] a, input int len, input bit byt, input bit stl);
    int target;
    @(posedge clk);
    b_addr = a; b_len = len; b_byte = byt; stall_mode = stl;
    target = done_cnt + 1;
    go = 1;
    wait (done_cnt == target);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    check(0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rom_ce_n_o && rom_oe_n_o, "R1 enables after reset", {rom_ce_n_o, rom_oe_n_o}, 3);
    check(!rd_valid_o && req_ready_o && rom_word_o, "R1 idle outputs",
          {rd_valid_o, req_ready_o, rom_word_o}, 3'b011);
    rst_n = 1'b1;
    run(20'h00010, 3, 0, 0);  // R5 one full page
    run(20'h00012, 4, 0, 0);  // R6 word crossing
    run(20'h00025, 5, 1, 0);  // R3 R6 byte crossing
    run(20'h00003, 0, 1, 0);  // R9 single beat
    run(20'h7FFF0, 7, 0, 1);  // R8 stalls, word
    run(20'hFFFF6, 9, 1, 1);  // R8 stalls, byte near top
    run(20'h0001F, 2, 1, 1);  // R11 back to back bursts
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule